// File: doc/BRIEF.md
# Dual-Output Step Pulse Timer

The block is one timer channel that produces step pulses for two stepper motor outputs, A and B. Both outputs share a free-running 16-bit up-counter. The counter advances on a tick taken from the system clock through a programmable divider. Each output has its own compare value. When the counter passes that value, the output rises. Hardware lowers it again after a fixed number of counts, so the pulse period and the pulse width both come out exact, whatever the interrupt service latency.

Software sees a small register file that is written and read through single-cycle strobes. Compare events are latched in a status word that is cleared on read. A mask, changed through separate set and clear addresses, gates the events onto one level-sensitive interrupt line. The line stays high until every unmasked pending event has been read out.

Top module: `step_pulse_timer`

## Requirements
- R1: After reset both step outputs and the interrupt are low, both compare values, the mask, the status word and the counter read as zero, and the counter does not advance.
- R2: A write to address 0 with bit 1 set forces the counter and the divider phase to zero in that cycle. While running, the counter advances by one every (D+1) clocks, where D is write-data bits [15:8] of the last address-0 write. It wraps from 0xFFFF to 0. Address 7 reads the counter.
- R3: On a tick where the counter equals compare A (address 1, read/write), step_a is high from the next cycle. Compare B (address 2) drives step_b the same way.
- R4: An output falls after the tick on which the counter equals its match value plus PULSE_W (default 20), computed modulo 2^16. Each pulse therefore lasts exactly PULSE_W ticks, even across the counter wrap.
- R5: A new match on an output that is already high keeps the output high without a gap and restarts the pulse end from the new match.
- R6: A match on A sets status bit 0 and a match on B sets status bit 1. Matches on both outputs in the same tick set both bits.
- R7: Reading address 6 returns the status word and clears it. An event in the same cycle as the read stays set.
- R8: irq is high exactly when some status bit is set whose mask bit is also set.
- R9: Writing ones to address 3 sets mask bits, and writing ones to address 4 clears them. Mask bit 0 is for A and bit 1 is for B. Address 5 reads the mask.
- R10: A write to address 0 with bit 0 clear stops the counter, which then holds its value. Bit 0 set lets it run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status at address 6) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of reg_rd, zero otherwise |
| step_a | output | 1 | Step pulse for output A |
| step_b | output | 1 | Step pulse for output B |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The assertions assume that reg_wr and reg_rd are never high together. They also assume that the set and clear mask addresses cannot be written in the same cycle, so the mask assertions never have to arbitrate between the two. The stimulus moves the strobes one cycle at a time, just after a rising edge, and always issues a single operation per cycle. A read that coincides with a match is placed by waiting until the bench's own counter value equals the compare value.

// File: rtl/step_timer_pkg.sv
package step_timer_pkg;

    typedef enum logic [2:0] {
        ADR_CTRL   = 3'd0,
        ADR_CMP_A  = 3'd1,
        ADR_CMP_B  = 3'd2,
        ADR_IE_SET = 3'd3,
        ADR_IE_CLR = 3'd4,
        ADR_MASK   = 3'd5,
        ADR_STAT   = 3'd6,
        ADR_COUNT  = 3'd7
    } reg_adr_e;

    localparam int CTRL_RUN_BIT     = 0;
    localparam int CTRL_RESTART_BIT = 1;
    localparam int CTRL_DIV_LSB     = 8;

endpackage

// File: rtl/step_tick_gen.sv
module step_tick_gen #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [DIV_W-1:0] phase;
        logic [CNT_W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     tick;

    always_comb begin
        tick = run_i && !restart_i && (st_q.phase >= div_i);
        st_d = st_q;
        if (restart_i) begin
            st_d.phase = '0;
            st_d.cnt   = '0;
        end else if (run_i) begin
            if (tick) begin
                st_d.phase = '0;
                st_d.cnt   = st_q.cnt + 1'b1;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = tick;
    assign cnt_o  = st_q.cnt;

    p_restart_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.cnt == '0));

    p_hold_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !restart_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/step_pulse_chan.sv
module step_pulse_chan #(
    parameter int CNT_W   = 16,
    parameter int PULSE_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             hit_o,
    output logic             out_o
);

    localparam logic [CNT_W-1:0] WIDTH_C = CNT_W'(PULSE_W);

    typedef struct packed {
        logic             high;
        logic [CNT_W-1:0] stop;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     hit;
    logic     at_end;

    always_comb begin
        hit    = tick_i && (cnt_i == cmp_i);
        at_end = tick_i && st_q.high && (cnt_i == st_q.stop);
        st_d   = st_q;
        if (hit) begin
            st_d.high = 1'b1;
            st_d.stop = cmp_i + WIDTH_C;
        end else if (at_end) begin
            st_d.high = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o = hit;
    assign out_o = st_q.high;

    p_rise_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> st_q.high);

    p_fall_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.high) |-> $past(at_end));

    p_retrigger_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.high && hit) |=> st_q.high);

endmodule

// File: rtl/step_irq_ctrl.sv
module step_irq_ctrl #(
    parameter int NUM_EV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] ev_i,
    input  logic              rd_clr_i,
    input  logic              set_wr_i,
    input  logic              clr_wr_i,
    input  logic [NUM_EV-1:0] wbits_i,
    output logic [NUM_EV-1:0] status_o,
    output logic [NUM_EV-1:0] mask_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [NUM_EV-1:0] status;
        logic [NUM_EV-1:0] mask;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.status = (rd_clr_i ? '0 : st_q.status) | ev_i;
        if (set_wr_i) st_d.mask = st_q.mask | wbits_i;
        if (clr_wr_i) st_d.mask = st_q.mask & ~wbits_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign irq_o    = |(st_q.status & st_q.mask);

    for (genvar g = 0; g < NUM_EV; g++) begin : g_chk
        p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[g] |=> st_q.status[g]);
        p_flag_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.status[g] && !rd_clr_i) |=> st_q.status[g]);
        p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (set_wr_i && !clr_wr_i && wbits_i[g]) |=> st_q.mask[g]);
        p_mask_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr_i && !set_wr_i && wbits_i[g]) |=> !st_q.mask[g]);
    end

endmodule

// File: rtl/step_pulse_timer.sv
module step_pulse_timer #(
    parameter int CNT_W   = 16,
    parameter int DIV_W   = 8,
    parameter int PULSE_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             step_a,
    output logic             step_b,
    output logic             irq
);
    import step_timer_pkg::*;

    localparam int NUM_OUT = 2;

    typedef struct packed {
        logic                            run;
        logic [DIV_W-1:0]                div;
        logic [NUM_OUT-1:0][CNT_W-1:0]   cmp;
    } top_st_t;

    top_st_t          st_d, st_q;
    reg_adr_e         adr;
    logic             restart;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [NUM_OUT-1:0] hit;
    logic [NUM_OUT-1:0] outs;
    logic [NUM_OUT-1:0] status;
    logic [NUM_OUT-1:0] mask;
    logic             irq_int;

    assign adr     = reg_adr_e'(reg_addr);
    assign restart = reg_wr && (adr == ADR_CTRL) && reg_wdata[CTRL_RESTART_BIT];

    always_comb begin
        st_d = st_q;
        if (reg_wr) begin
            unique case (adr)
                ADR_CTRL: begin
                    st_d.run = reg_wdata[CTRL_RUN_BIT];
                    st_d.div = reg_wdata[CTRL_DIV_LSB +: DIV_W];
                end
                ADR_CMP_A: st_d.cmp[0] = reg_wdata;
                ADR_CMP_B: st_d.cmp[1] = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    step_tick_gen #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (st_q.run),
        .restart_i(restart),
        .div_i    (st_q.div),
        .tick_o   (tick),
        .cnt_o    (cnt)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
        step_pulse_chan #(.CNT_W(CNT_W), .PULSE_W(PULSE_W)) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .tick_i(tick),
            .cnt_i (cnt),
            .cmp_i (st_q.cmp[g]),
            .hit_o (hit[g]),
            .out_o (outs[g])
        );
    end

    step_irq_ctrl #(.NUM_EV(NUM_OUT)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (hit),
        .rd_clr_i(reg_rd && (adr == ADR_STAT)),
        .set_wr_i(reg_wr && (adr == ADR_IE_SET)),
        .clr_wr_i(reg_wr && (adr == ADR_IE_CLR)),
        .wbits_i (reg_wdata[NUM_OUT-1:0]),
        .status_o(status),
        .mask_o  (mask),
        .irq_o   (irq_int)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (adr)
                ADR_CMP_A: reg_rdata = st_q.cmp[0];
                ADR_CMP_B: reg_rdata = st_q.cmp[1];
                ADR_MASK:  reg_rdata = {{(CNT_W-NUM_OUT){1'b0}}, mask};
                ADR_STAT:  reg_rdata = {{(CNT_W-NUM_OUT){1'b0}}, status};
                ADR_COUNT: reg_rdata = cnt;
                default:   reg_rdata = '0;
            endcase
        end
    end

    assign step_a = outs[0];
    assign step_b = outs[1];
    assign irq    = irq_int;

    p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

endmodule

// File: tb/tb_step_pulse_timer.sv
module tb_step_pulse_timer;
    localparam int W = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        step_a, step_b, irq;

    int checks = 0;
    int errors = 0;

    // reference model state
    int m_run, m_div, m_phase, m_cnt, m_stat, m_mask;
    int m_cmp [2];
    int m_hi  [2];
    int m_end [2];
    int restart_m, tick_m, ev_m;

    always #4 clk = ~clk;

    step_pulse_timer dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .step_a(step_a), .step_b(step_b), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_div = 0; m_phase = 0; m_cnt = 0; m_stat = 0; m_mask = 0;
            for (int i = 0; i < 2; i++) begin m_cmp[i] = 0; m_hi[i] = 0; m_end[i] = 0; end
        end else begin
            restart_m = (reg_wr && reg_addr == 3'd0 && reg_wdata[1]) ? 1 : 0;
            tick_m    = (m_run != 0 && restart_m == 0 && m_phase >= m_div) ? 1 : 0;
            ev_m      = 0;
            for (int i = 0; i < 2; i++) begin
                if (tick_m != 0 && m_cnt == m_cmp[i]) begin
                    m_hi[i] = 1; m_end[i] = (m_cmp[i] + W) % 65536; ev_m |= (1 << i);
                end else if (tick_m != 0 && m_hi[i] != 0 && m_cnt == m_end[i]) begin
                    m_hi[i] = 0;
                end
            end
            if (reg_rd && reg_addr == 3'd6) m_stat = 0;
            m_stat |= ev_m;
            if (restart_m != 0) begin
                m_cnt = 0; m_phase = 0;
            end else if (m_run != 0) begin
                if (tick_m != 0) begin m_cnt = (m_cnt + 1) % 65536; m_phase = 0; end
                else m_phase++;
            end
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: begin m_run = reg_wdata[0]; m_div = reg_wdata[15:8]; end
                    3'd1: m_cmp[0] = reg_wdata;
                    3'd2: m_cmp[1] = reg_wdata;
                    3'd3: m_mask = m_mask | (reg_wdata & 3);
                    3'd4: m_mask = m_mask & ~int'(reg_wdata) & 3;
                    default: ;
                endcase
            end
        end
    end

    // compare outputs every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int exp_rd;
            check(step_a == m_hi[0][0], "R3 R4 R5 step_a", step_a, m_hi[0]);
            check(step_b == m_hi[1][0], "R3 R4 R5 step_b", step_b, m_hi[1]);
            check(irq == ((m_stat & m_mask) != 0), "R8 irq", irq, (m_stat & m_mask) != 0);
            if (reg_rd) begin
                case (reg_addr)
                    3'd1: exp_rd = m_cmp[0];
                    3'd2: exp_rd = m_cmp[1];
                    3'd5: exp_rd = m_mask;
                    3'd6: exp_rd = m_stat;
                    3'd7: exp_rd = m_cnt;
                    default: exp_rd = 0;
                endcase
                case (reg_addr)
                    3'd5: check(int'(reg_rdata) == exp_rd, "R9 mask read", reg_rdata, exp_rd);
                    3'd6: check(int'(reg_rdata) == exp_rd, "R6 R7 status read", reg_rdata, exp_rd);
                    3'd7: check(int'(reg_rdata) == exp_rd, "R2 R10 count read", reg_rdata, exp_rd);
                    default: check(int'(reg_rdata) == exp_rd, "R3 compare read", reg_rdata, exp_rd);
                endcase
            end
        end
    end

    task automatic op(input bit wr, input bit rd, input int a, input int d);
        reg_wr = wr; reg_rd = rd; reg_addr = 3'(a); reg_wdata = 16'(d);
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #2;
        check(step_a == 1'b0 && step_b == 1'b0 && irq == 1'b0, "R1 outputs in reset",
              {step_a, step_b, irq}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R1: reset values read as zero, counter idle
        reg_rd = 1'b1; reg_addr = 3'd1; #2;
        check(reg_rdata == 16'd0, "R1 compare A after reset", reg_rdata, 0);
        reg_addr = 3'd2; #1;
        check(reg_rdata == 16'd0, "R1 compare B after reset", reg_rdata, 0);
        reg_addr = 3'd5; #1;
        check(reg_rdata == 16'd0, "R1 mask after reset", reg_rdata, 0);
        reg_addr = 3'd7; #1;
        check(reg_rdata == 16'd0, "R1 counter after reset", reg_rdata, 0);
        reg_rd = 1'b0; reg_addr = '0;
        idle(3);
        op(0, 1, 7, 0);
        op(0, 1, 6, 0);

        // R6: both matches in one tick, R8 irq with both enabled
        op(1, 0, 1, 10);
        op(1, 0, 2, 10);
        op(1, 0, 3, 3);
        op(1, 0, 0, 16'h0003);
        idle(15);
        check(irq == 1'b1, "R8 irq after double match", irq, 1);
        op(0, 1, 6, 0);
        check(irq == 1'b0, "R7 irq low after status read", irq, 0);
        idle(20);

        // R5: retrigger while high
        op(1, 0, 1, 50);
        while (m_cnt != 55) idle(1);
        op(1, 0, 1, 60);
        idle(40);

        // R7: read in the cycle of a match keeps the new flag
        op(0, 1, 6, 0);
        op(1, 0, 2, 200);
        while (m_cnt != 200) idle(1);
        op(0, 1, 6, 0);
        op(0, 1, 6, 0);

        // R9: disable A, only B may raise irq
        op(1, 0, 4, 1);
        op(0, 1, 5, 0);
        op(1, 0, 1, 230);
        idle(40);
        check(irq == 1'b0, "R9 masked A leaves irq low", irq, 0);
        op(1, 0, 3, 1);
        check(irq == 1'b1, "R9 re-enabled A raises irq", irq, 1);
        op(0, 1, 6, 0);

        // R10: stop and hold
        op(1, 0, 0, 16'h0000);
        op(0, 1, 7, 0);
        idle(10);
        op(0, 1, 7, 0);

        // R2: divider of 4
        op(1, 0, 1, 5);
        op(1, 0, 2, 7);
        op(1, 0, 0, 16'h0303);
        idle(130);
        op(0, 1, 7, 0);
        op(0, 1, 6, 0);

        // R4: pulse across the wrap
        op(1, 0, 2, 16'hFFF5);
        op(1, 0, 1, 4);
        op(1, 0, 0, 16'h0003);
        idle(65536 + 40);
        op(0, 1, 7, 0);
        op(0, 1, 6, 0);
        idle(5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule